// File: doc/BRIEF.md
# Six-Bit Successive-Approximation Conversion Sequencer

This block runs a six-bit successive-approximation conversion. It drives a trial code into an external resistor ladder and reads back one comparator bit. The bits are resolved one at a time, starting with the most significant. At each step the bit under test is set to 1. It is kept only when the comparator reports that the input is at or above the ladder level. The ladder and the comparator sit outside the block.

The ladder is expected to span 63/96 of the supply at code 3Fh, so one step is 1/96 of the supply. Its level for a trial code is taken to lie half a step below the nominal code. Because of that offset, the settled result is the code nearest to the input, within plus or minus half a step. The conversion time is split into six equal bit periods of `TICKS_PER_BIT` clocks each. At the default timing of the target system, the six periods together last 1.28 ms (about 213 µs per bit). The parameter sets the clock count per period. A start strobe is accepted only while the block is idle. The result register and a one-cycle done flag both update when the last bit is decided.

Top module: `sar6_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy_o`, `done_o`, `trial_o` and `result_o` are all 0.
- R2: A start strobe sampled while idle makes `busy_o` 1 on the next cycle, and `trial_o` becomes 100000b (only bit 5 set).
- R3: Bits are resolved from bit 5 down to bit 0. During the period for bit k, `trial_o` holds the decisions already made above k, a 1 at bit k and zeros below. Bit k is kept as 1 only if `comp_i` is 1 on the last clock of its period.
- R4: Every bit period lasts `TICKS_PER_BIT` clocks, so `done_o` rises exactly 6 × `TICKS_PER_BIT` clocks after the edge that accepted the start.
- R5: `done_o` is high for exactly one clock, and `busy_o` is 0 in that same clock.
- R6: `result_o` changes only on the edge that raises `done_o`, and holds its value at all other times, including during a conversion.
- R7: A start strobe while `busy_o` is 1 has no effect: the trial sequence, the done timing and the result are the same as without it.
- R8: A conversion started after a completed one begins from 100000b, whatever the previous result was.
- R9: An input above the top ladder level (comparator always 1) saturates the result at 3Fh. An input at zero gives 00h.
- R10: With a ladder whose level for code c lies half a step below c, the result is the nearest code to the input, clamped to 3Fh.
- R11: While `busy_o` is 0, `trial_o` is 000000b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; accepted only when idle |
| comp_i | input | 1 | Comparator: 1 when the input is at or above the ladder level |
| trial_o | output | 6 | Trial code driven to the ladder |
| result_o | output | 6 | Last completed conversion result |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-clock pulse when the last bit is decided |

## Verification
The assertions assume that reset is held low from time zero until after the first clock edge. They also assume that `comp_i` is a settled, synchronous level on every edge, since the block samples it without any synchroniser. The bench respects both. It holds reset over several edges. Its comparator model is a combinational compare of a fixed input level against the trial code, and that input level changes only while the block is idle. Start strobes are driven at the falling edge, and some are placed deliberately inside a running conversion.

// File: rtl/sar6_pkg.sv
package sar6_pkg;
   typedef enum logic {
      CONV_IDLE = 1'b0,
      CONV_RUN  = 1'b1
   } conv_state_e;

   function automatic int unsigned total_cycles(input int unsigned bits,
                                                input int unsigned ticks);
      return bits * ticks;
   endfunction
endpackage

// File: rtl/sar6_bit_timer.sv
module sar6_bit_timer #(
   parameter int unsigned TICKS_PER_BIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic run_i,
   output logic period_end_o
);
   generate
      if (TICKS_PER_BIT < 1) begin : g_bad
         $error("TICKS_PER_BIT must be at least 1");
      end
      if (TICKS_PER_BIT == 1) begin : g_single
         assign period_end_o = run_i;
      end else begin : g_count
         localparam int unsigned CW = $clog2(TICKS_PER_BIT);
         localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);
         logic [CW-1:0] tick_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tick_q <= '0;
            end else if (clear_i) begin
               tick_q <= '0;
            end else if (run_i) begin
               tick_q <= (tick_q == LAST) ? '0 : tick_q + 1'b1;
            end
         end
         assign period_end_o = run_i && (tick_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/sar6_bit_pointer.sv
module sar6_bit_pointer #(
   parameter int unsigned NBITS = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   output logic [NBITS-1:0] ptr_o,
   output logic             last_o
);
   localparam logic [NBITS-1:0] TOP = {1'b1, {(NBITS-1){1'b0}}};
   logic [NBITS-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (load_i) begin
         ptr_q <= TOP;
      end else if (step_i) begin
         ptr_q <= ptr_q >> 1;
      end
   end

   assign ptr_o  = ptr_q;
   assign last_o = ptr_q[0];
endmodule

// File: rtl/sar6_trial_reg.sv
module sar6_trial_reg #(
   parameter int unsigned NBITS = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             clear_i,
   input  logic             step_i,
   input  logic             comp_i,
   input  logic [NBITS-1:0] ptr_i,
   output logic [NBITS-1:0] code_o
);
   genvar i;
   generate
      for (i = 0; i < NBITS; i++) begin : g_bit
         logic bit_q;
         logic arm_next;
         if (i == NBITS - 1) begin : g_top
            assign arm_next = 1'b0;
         end else begin : g_low
            assign arm_next = ptr_i[i+1];
         end
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               bit_q <= 1'b0;
            end else if (load_i) begin
               bit_q <= (i == NBITS - 1);
            end else if (clear_i) begin
               bit_q <= 1'b0;
            end else if (step_i) begin
               if (ptr_i[i]) begin
                  bit_q <= comp_i;
               end else if (arm_next) begin
                  bit_q <= 1'b1;
               end
            end
         end
         assign code_o[i] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/sar6_seq.sv
module sar6_seq #(
   parameter int unsigned RES_BITS      = 6,
   parameter int unsigned TICKS_PER_BIT = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                comp_i,
   output logic [RES_BITS-1:0] trial_o,
   output logic [RES_BITS-1:0] result_o,
   output logic                busy_o,
   output logic                done_o
);
   import sar6_pkg::*;

   generate
      if (RES_BITS < 2 || RES_BITS > 16) begin : g_bad_width
         $error("RES_BITS must lie between 2 and 16");
      end
   endgenerate

   conv_state_e         state_q;
   logic                accept;
   logic                period_end;
   logic                last_bit;
   logic                finish;
   logic [RES_BITS-1:0] ptr;
   logic [RES_BITS-1:0] code;
   logic [RES_BITS-1:0] settled;
   logic [RES_BITS-1:0] result_q;
   logic                done_q;

   assign accept = start_i && (state_q == CONV_IDLE);
   assign finish = period_end && last_bit;

   sar6_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (accept),
      .run_i        (state_q == CONV_RUN),
      .period_end_o (period_end)
   );

   sar6_bit_pointer #(.NBITS(RES_BITS)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .step_i (period_end),
      .ptr_o  (ptr),
      .last_o (last_bit)
   );

   sar6_trial_reg #(.NBITS(RES_BITS)) u_trial (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .clear_i (finish),
      .step_i  (period_end),
      .comp_i  (comp_i),
      .ptr_i   (ptr),
      .code_o  (code)
   );

   assign settled = (code & ~ptr) | ({RES_BITS{comp_i}} & ptr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= CONV_IDLE;
         result_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= finish;
         case (state_q)
            CONV_IDLE: if (accept) state_q <= CONV_RUN;
            CONV_RUN: begin
               if (finish) begin
                  state_q  <= CONV_IDLE;
                  result_q <= settled;
               end
            end
            default: state_q <= CONV_IDLE;
         endcase
      end
   end

   assign trial_o  = code;
   assign result_o = result_q;
   assign busy_o   = (state_q == CONV_RUN);
   assign done_o   = done_q;
endmodule

// File: rtl/sar6_seq_chk.sv
module sar6_seq_chk #(
   parameter int unsigned RES_BITS      = 6,
   parameter int unsigned TICKS_PER_BIT = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic [RES_BITS-1:0] trial_o,
   input logic [RES_BITS-1:0] result_o,
   input logic                busy_o,
   input logic                done_o
);
   localparam logic [RES_BITS-1:0] TOP = {1'b1, {(RES_BITS-1){1'b0}}};
   localparam int unsigned SPAN = sar6_pkg::total_cycles(RES_BITS, TICKS_PER_BIT);

   int unsigned span_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) span_cnt <= 0;
      else if (start_i && !busy_o) span_cnt <= 0;
      else if (busy_o) span_cnt <= span_cnt + 1;
   end

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R5
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));
   // R11
   idle_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (trial_o == '0));
   // R2
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && trial_o == TOP));
   // R7
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o) |=> (busy_o || done_o));
   // R4
   span_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (span_cnt == SPAN));
endmodule

bind sar6_seq sar6_seq_chk #(
   .RES_BITS      (RES_BITS),
   .TICKS_PER_BIT (TICKS_PER_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .trial_o  (trial_o),
   .result_o (result_o),
   .busy_o   (busy_o),
   .done_o   (done_o)
);

// File: tb/sar6_seq_tb.sv
module sar6_seq_tb;
   localparam int T = 4;
   localparam int N = 6;
   localparam int NVEC = 12;
   // input level in half-step units, expected result
   localparam int VEC_IN [NVEC] = '{0, 1, 2, 3, 63, 64, 65, 124, 125, 126, 200, 255};
   localparam int VEC_EX [NVEC] = '{0, 1, 1, 2, 32, 32, 33, 62, 63, 63, 63, 63};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic comp_i;
   logic [N-1:0] trial_o, result_o;
   logic busy_o, done_o;
   int ain = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit ended = 0;

   always #4 clk = ~clk;

   // ladder level for code c sits half a step below c
   always_comb comp_i = (ain + 1 >= 2 * int'(trial_o));

   sar6_seq #(.RES_BITS(N), .TICKS_PER_BIT(T)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .comp_i(comp_i),
      .trial_o(trial_o), .result_o(result_o), .busy_o(busy_o), .done_o(done_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // start at a falling edge; done expected at falling edge 6T+1 after it
   task automatic convert(input int level, input int exp, input int busy_start_at);
      int k;
      int prev;
      ain = level;
      prev = int'(result_o);
      start_i = 1'b1;
      k = 0;
      while (!done_o && k < 1000) begin
         @(negedge clk);
         k++;
         start_i = (k == busy_start_at);
         if (k == 1) begin
            chk(busy_o && trial_o == 6'b100000, "R2/R8 load", int'(trial_o), 32);
         end
         if (k == T + 1) begin
            chk(trial_o == ((exp & 32) | 16), "R3 second period", int'(trial_o), (exp & 32) | 16);
         end
         if (k == 3 * T) begin
            chk(int'(result_o) == prev, "R6 hold", int'(result_o), prev);
         end
      end
      start_i = 1'b0;
      chk(k == 6 * T + 1, "R4 span", k, 6 * T + 1);
      chk(!busy_o, "R5 busy low", int'(busy_o), 0);
      chk(int'(result_o) == exp, "R10/R9 result", int'(result_o), exp);
      @(negedge clk);
      chk(!done_o, "R5 pulse width", int'(done_o), 0);
      chk(trial_o == 0, "R11 idle trial", int'(trial_o), 0);
   endtask

   initial begin
      #100000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy_o && !done_o && trial_o == 0 && result_o == 0, "R1 in reset",
          int'(result_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !done_o && trial_o == 0 && result_o == 0, "R1 after reset",
          int'(trial_o), 0);

      for (int i = 0; i < NVEC; i++) convert(VEC_IN[i], VEC_EX[i], 0);

      // R9 saturation then R8 restart from top bit with zero input
      convert(255, 63, 0);
      convert(0, 0, 0);
      // R7 start strobe mid-conversion ignored
      convert(101, 51, 2 * T);
      convert(37, 19, T + 1);
      // R6 result unchanged while idle
      repeat (5) @(negedge clk);
      chk(result_o == 19, "R6 idle hold", int'(result_o), 19);
      finish_run();
   end
endmodule